// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block gathers up to 32 level-sensitive interrupt requests and presents them on two outputs: a normal interrupt line and a fast interrupt line. Each source has its own enable bit and its own routing bit, and software can raise any source by itself. All state is reached over a simple word-addressed read/write strobe bus. A privilege input lets a protection bit lock out unprivileged writes.

A table of 16 prioritised vector slots maps sources to handler addresses. Each slot holds a control word, which gives a slot enable and a source number, and a handler address. A read of the current-vector register returns the handler address of the best slot whose source is pending on the normal line. Slot 0 has the highest priority. If no slot qualifies, the read returns a programmable default address. The read also records that slot's priority level as in service, so that only slots of higher priority can be returned until software writes the same register to end service. The block also provides four identification bytes and a clearable test-control register.

Top module: `vic_ctrl`

## Requirements
- R1: After reset, the enable, routing, software-request, protection, test-control and in-service state are all zero, both status registers read 0, and both interrupt outputs are low.
- R2: A write to offset 0x010 sets every enable bit written as 1. A write to offset 0x014 clears every enable bit written as 1. Bits written as 0 leave their state unchanged. A read of 0x010 returns the enable mask.
- R3: Software requests follow the same set/clear rule, with set at 0x018 and clear at 0x01C. A read of 0x018 returns the software-request mask.
- R4: Each request is the OR of its hardware input and its software bit, ANDed with its enable. Offset 0x000 returns the requests whose routing bit (offset 0x00C) is 0. Offset 0x004 returns those whose routing bit is 1. Hardware inputs pass through one sampling register first.
- R5: The normal output is the registered OR of the 0x000 status, and the fast output is the registered OR of the 0x004 status. A hardware input change therefore reaches its output on the second rising edge.
- R6: Slot i has a handler address at 0x100+4i and a control word at 0x200+4i. In the control word, bit 5 enables the slot and bits 4:0 give its source number. The control word reads back as only those six bits.
- R7: A read of 0x030 returns the handler address of the lowest-numbered enabled slot whose source is set in the 0x000 status. If there is none, it returns the default address held at 0x034.
- R8: A read of 0x030 that returns a slot marks that slot as in service. Later reads may only return slots with a lower number than any slot in service, and return the default address otherwise.
- R9: A write to 0x030 removes the highest-priority in-service level. Repeated writes clear all of them.
- R10: Bit 0 of 0x020 is the protection bit. While it is set, writes with the privilege input low are ignored for every register. Privileged writes still take effect.
- R11: Offsets 0xFE0, 0xFE4, 0xFE8 and 0xFEC return the bytes of the 32-bit identification word in their low 8 bits, least significant byte first. Bits 19:12 of the word are a vendor code.
- R12: The test-control register at 0x300 holds bit 0. It reads back what was written, and writing 0 returns it to normal mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_priv | input | 1 | Access is privileged |
| bus_addr | input | 12 | Byte address within the block |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the strobe |
| irq_src | input | 32 | Level-sensitive hardware requests |
| irq_out | output | 1 | Normal interrupt output, active high |
| fiq_out | output | 1 | Fast interrupt output, active high |

## Verification
The bench builds nested service. A lower-priority slot is taken first, and a higher one then preempts it. A design that ignored in-service state would return the blocked lower slot again, and one that ignored preemption would return the default address. It then ends service one level at a time and checks that only the top level drops each time. Acknowledging too much, or too little, shows up as the wrong handler address on the next read. It also checks that a source routed to the fast line drops out of vector selection, that writes of 0 to the set/clear registers leave state unchanged, that unprivileged writes (including one to the protection bit itself) have no effect while protection is on, and the exact two-edge latency from a hardware input to its output.

// File: rtl/vic_pkg.sv
// Package: shared address map, field positions and bus request type.
// Assumes a 12-bit byte address and 32-bit data words.
package vic_pkg;
    localparam int unsigned ADDR_W = 12;
    localparam int unsigned DATA_W = 32;

    localparam logic [ADDR_W-1:0] OFF_IRQ_STAT   = 12'h000;
    localparam logic [ADDR_W-1:0] OFF_FIQ_STAT   = 12'h004;
    localparam logic [ADDR_W-1:0] OFF_ROUTE      = 12'h00C;
    localparam logic [ADDR_W-1:0] OFF_EN_SET     = 12'h010;
    localparam logic [ADDR_W-1:0] OFF_EN_CLR     = 12'h014;
    localparam logic [ADDR_W-1:0] OFF_SW_SET     = 12'h018;
    localparam logic [ADDR_W-1:0] OFF_SW_CLR     = 12'h01C;
    localparam logic [ADDR_W-1:0] OFF_LOCK       = 12'h020;
    localparam logic [ADDR_W-1:0] OFF_CUR_VEC    = 12'h030;
    localparam logic [ADDR_W-1:0] OFF_DFLT_VEC   = 12'h034;
    localparam int unsigned       OFF_HADDR_BASE = 'h100;
    localparam int unsigned       OFF_SCTL_BASE  = 'h200;
    localparam logic [ADDR_W-1:0] OFF_TESTCTL    = 12'h300;
    localparam logic [7:0]        ID_PAGE        = 8'hFE;

    // Slot control word: enable flag position
    localparam int unsigned SCTL_EN_BIT = 5;

    // Qualified bus request handed to the storage blocks
    typedef struct packed {
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } bus_req_t;
endpackage

// File: rtl/vic_cfg_regs.sv
// Module: per-source configuration storage (enable, routing, software
// requests), protection bit, default handler address and test control.
// Assumes req.wr is already qualified by the protection check.
module vic_cfg_regs
    import vic_pkg::*;
#(
    parameter int unsigned NUM_SRC = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  bus_req_t            req,
    output logic [NUM_SRC-1:0]  en_q,
    output logic [NUM_SRC-1:0]  route_q,
    output logic [NUM_SRC-1:0]  soft_q,
    output logic                lock_q,
    output logic [DATA_W-1:0]   dflt_q,
    output logic                test_q
);
    logic [NUM_SRC-1:0] wbits;
    assign wbits = req.wdata[NUM_SRC-1:0];

    // Register updates: set/clear pairs, plain fields
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q    <= '0;
            route_q <= '0;
            soft_q  <= '0;
            lock_q  <= 1'b0;
            dflt_q  <= '0;
            test_q  <= 1'b0;
        end else if (req.wr) begin
            case (req.addr)
                OFF_ROUTE:    route_q <= wbits;
                OFF_EN_SET:   en_q    <= en_q | wbits;
                OFF_EN_CLR:   en_q    <= en_q & ~wbits;
                OFF_SW_SET:   soft_q  <= soft_q | wbits;
                OFF_SW_CLR:   soft_q  <= soft_q & ~wbits;
                OFF_LOCK:     lock_q  <= req.wdata[0];
                OFF_DFLT_VEC: dflt_q  <= req.wdata;
                OFF_TESTCTL:  test_q  <= req.wdata[0];
                default: ;
            endcase
        end
    end

    // R2: a set write never drops an enable bit
    a_r2_set_keeps_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (req.wr && req.addr == OFF_EN_SET) |=> ((en_q & $past(en_q)) == $past(en_q)));
    // R2: a clear write never raises an enable bit
    a_r2_clr_adds_none: assert property (@(posedge clk) disable iff (!rst_n)
        (req.wr && req.addr == OFF_EN_CLR) |=> ((en_q | $past(en_q)) == $past(en_q)));
endmodule

// File: rtl/vic_slot_table.sv
// Module: vector slot table. Each slot stores a handler address and a
// control word (enable + source number) and reports a hit when its source
// is pending on the normal line. Assumes NUM_SRC is a power of two.
module vic_slot_table
    import vic_pkg::*;
#(
    parameter int unsigned NUM_SRC   = 32,
    parameter int unsigned NUM_SLOTS = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  bus_req_t                    req,
    input  logic [NUM_SRC-1:0]          pend_norm,
    input  logic [$clog2(NUM_SLOTS)-1:0] win_idx,
    output logic [NUM_SLOTS-1:0]        hit,
    output logic [DATA_W-1:0]           win_haddr,
    output logic                        rd_match,
    output logic [DATA_W-1:0]           rd_data
);
    localparam int unsigned SRC_W = $clog2(NUM_SRC);

    logic [DATA_W-1:0] haddr_q [NUM_SLOTS];
    logic              sen_q   [NUM_SLOTS];
    logic [SRC_W-1:0]  ssrc_q  [NUM_SLOTS];

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
        localparam logic [ADDR_W-1:0] A_HADDR = ADDR_W'(OFF_HADDR_BASE + 4*i);
        localparam logic [ADDR_W-1:0] A_SCTL  = ADDR_W'(OFF_SCTL_BASE + 4*i);

        // Slot storage: handler address and control word
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                haddr_q[i] <= '0;
                sen_q[i]   <= 1'b0;
                ssrc_q[i]  <= '0;
            end else if (req.wr && req.addr == A_HADDR) begin
                haddr_q[i] <= req.wdata;
            end else if (req.wr && req.addr == A_SCTL) begin
                sen_q[i]   <= req.wdata[SCTL_EN_BIT];
                ssrc_q[i]  <= req.wdata[SRC_W-1:0];
            end
        end

        // Slot hit: enabled and its source pending on the normal line
        assign hit[i] = sen_q[i] & pend_norm[ssrc_q[i]];
    end

    // Handler address of the selected slot
    assign win_haddr = haddr_q[win_idx];

    // Read-back mux over the slot registers
    always_comb begin
        rd_match = 1'b0;
        rd_data  = '0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (req.addr == ADDR_W'(OFF_HADDR_BASE + 4*i)) begin
                rd_match = 1'b1;
                rd_data  = haddr_q[i];
            end
            if (req.addr == ADDR_W'(OFF_SCTL_BASE + 4*i)) begin
                rd_match = 1'b1;
                rd_data  = DATA_W'({sen_q[i], ssrc_q[i]});
            end
        end
    end
endmodule

// File: rtl/vic_prio.sv
// Module: priority selection and in-service tracking. Slot 0 is the most
// urgent. A slot is eligible only if no slot of equal or higher priority is
// in service. Assumes rd_ack and end_ack never coincide.
module vic_prio #(
    parameter int unsigned NUM_SLOTS = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM_SLOTS-1:0]         hit,
    input  logic                         rd_ack,
    input  logic                         end_ack,
    output logic                         win_valid,
    output logic [$clog2(NUM_SLOTS)-1:0] win_idx,
    output logic [NUM_SLOTS-1:0]         insvc_q
);
    localparam int unsigned IDX_W = $clog2(NUM_SLOTS);

    logic [NUM_SLOTS-1:0] blocked;
    logic [NUM_SLOTS-1:0] cand;

    // Blocking prefix: a slot is blocked by any in-service slot at or above it
    assign blocked[0] = insvc_q[0];
    for (genvar i = 1; i < NUM_SLOTS; i++) begin : g_blk
        assign blocked[i] = blocked[i-1] | insvc_q[i];
    end
    assign cand = hit & ~blocked;

    // Lowest-numbered eligible candidate
    always_comb begin
        win_valid = 1'b0;
        win_idx   = '0;
        for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
            if (cand[i]) begin
                win_valid = 1'b1;
                win_idx   = IDX_W'(i);
            end
        end
    end

    // In-service state: mark on vector read, drop top level on end write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            insvc_q <= '0;
        end else if (rd_ack && win_valid) begin
            insvc_q[win_idx] <= 1'b1;
        end else if (end_ack) begin
            insvc_q <= insvc_q & (insvc_q - 1'b1);
        end
    end

    // R8: a vector read that returns a slot leaves that slot in service
    a_r8_mark_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ack && win_valid) |=> insvc_q[$past(win_idx)]);
    // R8: in-service levels are only added by a vector read
    a_r8_grow_only_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_ack |=> ($countones(insvc_q) <= $countones($past(insvc_q))));
    // R9: an end-of-service write removes exactly one level
    a_r9_drop_one_level: assert property (@(posedge clk) disable iff (!rst_n)
        (end_ack && insvc_q != '0) |=> ($countones(insvc_q) + 1 == $countones($past(insvc_q))));
endmodule

// File: rtl/vic_ctrl.sv
// Module: vectored interrupt controller top. Samples hardware requests,
// forms the two status words and registered outputs, qualifies bus writes
// against protection, and muxes read data. Assumes one access per strobe.
module vic_ctrl
    import vic_pkg::*;
#(
    parameter int unsigned NUM_SRC   = 32,
    parameter int unsigned NUM_SLOTS = 16,
    parameter logic [31:0] ID_WORD   = 32'h0004_1190
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_sel,
    input  logic                bus_wr,
    input  logic                bus_priv,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic [NUM_SRC-1:0]  irq_src,
    output logic                irq_out,
    output logic                fiq_out
);
    localparam int unsigned IDX_W = $clog2(NUM_SLOTS);

    logic [NUM_SRC-1:0]   src_q, en_q, route_q, soft_q;
    logic [NUM_SRC-1:0]   pend, stat_norm, stat_fast;
    logic                 lock_q, test_q;
    logic [DATA_W-1:0]    dflt_q, win_haddr, tbl_rdata;
    logic                 tbl_match, win_valid, rd_ack, end_ack, wr_ok;
    logic [NUM_SLOTS-1:0] hit, insvc_q;
    logic [IDX_W-1:0]     win_idx;
    bus_req_t             req;

    // Write qualification against the protection bit
    assign wr_ok   = bus_sel && bus_wr && (!lock_q || bus_priv);
    assign req.wr    = wr_ok;
    assign req.addr  = bus_addr;
    assign req.wdata = bus_wdata;
    assign rd_ack  = bus_sel && !bus_wr && bus_addr == OFF_CUR_VEC;
    assign end_ack = wr_ok && bus_addr == OFF_CUR_VEC;

    vic_cfg_regs #(.NUM_SRC(NUM_SRC)) u_regs (
        .clk(clk), .rst_n(rst_n), .req(req),
        .en_q(en_q), .route_q(route_q), .soft_q(soft_q),
        .lock_q(lock_q), .dflt_q(dflt_q), .test_q(test_q)
    );

    vic_slot_table #(.NUM_SRC(NUM_SRC), .NUM_SLOTS(NUM_SLOTS)) u_table (
        .clk(clk), .rst_n(rst_n), .req(req), .pend_norm(stat_norm),
        .win_idx(win_idx), .hit(hit), .win_haddr(win_haddr),
        .rd_match(tbl_match), .rd_data(tbl_rdata)
    );

    vic_prio #(.NUM_SLOTS(NUM_SLOTS)) u_prio (
        .clk(clk), .rst_n(rst_n), .hit(hit), .rd_ack(rd_ack),
        .end_ack(end_ack), .win_valid(win_valid), .win_idx(win_idx),
        .insvc_q(insvc_q)
    );

    // Status words: combined requests split by routing
    assign pend      = (src_q | soft_q) & en_q;
    assign stat_norm = pend & ~route_q;
    assign stat_fast = pend & route_q;

    // Input sampling and registered interrupt outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q   <= '0;
            irq_out <= 1'b0;
            fiq_out <= 1'b0;
        end else begin
            src_q   <= irq_src;
            irq_out <= |stat_norm;
            fiq_out <= |stat_fast;
        end
    end

    // Read data mux
    always_comb begin
        bus_rdata = '0;
        if (tbl_match) begin
            bus_rdata = tbl_rdata;
        end else if (bus_addr[ADDR_W-1:4] == ID_PAGE) begin
            bus_rdata = DATA_W'(ID_WORD[8*bus_addr[3:2] +: 8]);
        end else begin
            case (bus_addr)
                OFF_IRQ_STAT: bus_rdata = DATA_W'(stat_norm);
                OFF_FIQ_STAT: bus_rdata = DATA_W'(stat_fast);
                OFF_ROUTE:    bus_rdata = DATA_W'(route_q);
                OFF_EN_SET:   bus_rdata = DATA_W'(en_q);
                OFF_SW_SET:   bus_rdata = DATA_W'(soft_q);
                OFF_LOCK:     bus_rdata = DATA_W'(lock_q);
                OFF_CUR_VEC:  bus_rdata = win_valid ? win_haddr : dflt_q;
                OFF_DFLT_VEC: bus_rdata = dflt_q;
                OFF_TESTCTL:  bus_rdata = DATA_W'(test_q);
                default:      bus_rdata = '0;
            endcase
        end
    end

    // R1: outputs are low on the cycle after any reset cycle
    a_r1_outputs_clear: assert property (@(posedge clk)
        !rst_n |=> (!irq_out && !fiq_out));
    // R10: a blocked write changes no per-source state
    a_r10_blocked_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && lock_q && !bus_priv)
        |=> ($stable(en_q) && $stable(route_q) && $stable(soft_q) && $stable(lock_q) && $stable(insvc_q)));
endmodule

// File: tb/vic_ctrl_tb.sv
`timescale 1ns/1ps
module vic_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0, bus_priv = 1'b1;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] irq_src = '0;
    logic        irq_out, fiq_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    vic_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_priv(bus_priv), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_src(irq_src), .irq_out(irq_out),
        .fiq_out(fiq_out)
    );

    // Vectors: hw src, enable, route, expected normal status, expected fast status
    localparam logic [31:0] VTAB [6][5] = '{
        '{32'hFFFF_FFFF, 32'h0000_0000, 32'h0000_0000, 32'h0000_0000, 32'h0000_0000},
        '{32'h0000_00FF, 32'h0000_000F, 32'h0000_0000, 32'h0000_000F, 32'h0000_0000},
        '{32'h0000_00FF, 32'h0000_00FF, 32'h0000_00F0, 32'h0000_000F, 32'h0000_00F0},
        '{32'h8000_0001, 32'hFFFF_FFFF, 32'h8000_0000, 32'h0000_0001, 32'h8000_0000},
        '{32'h0000_0000, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_0000, 32'h0000_0000},
        '{32'h1234_5678, 32'hFFFF_0000, 32'h0F0F_0F0F, 32'h1030_0000, 32'h0204_0000}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic priv = 1'b1);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_priv = priv;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_priv = 1'b1;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic rd_chk(input logic [11:0] a, input logic [31:0] exp, input string req);
        logic [31:0] d;
        rd(a, d);
        check(req, d, exp);
    endtask

    task automatic end_all();
        for (int k = 0; k < 20; k++) wr(12'h030, 32'h0);
    endtask

    // Watchdog
    initial begin
        #800000;
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check("R1 irq_out", 32'(irq_out), 0);
        check("R1 fiq_out", 32'(fiq_out), 0);
        rd_chk(12'h000, 0, "R1 normal status");
        rd_chk(12'h004, 0, "R1 fast status");
        rd_chk(12'h010, 0, "R1 enable");
        rd_chk(12'h00C, 0, "R1 route");
        rd_chk(12'h018, 0, "R1 soft");
        rd_chk(12'h020, 0, "R1 lock");
        rd_chk(12'h300, 0, "R1 test control");

        // R4 R5: table of status vectors
        for (int v = 0; v < 6; v++) begin
            wr(12'h014, 32'hFFFF_FFFF);
            wr(12'h010, VTAB[v][1]);
            wr(12'h00C, VTAB[v][2]);
            @(negedge clk) irq_src = VTAB[v][0];
            repeat (3) @(negedge clk);
            rd_chk(12'h000, VTAB[v][3], "R4 normal status vector");
            rd_chk(12'h004, VTAB[v][4], "R4 fast status vector");
            check("R5 irq_out vector", 32'(irq_out), 32'(|VTAB[v][3]));
            check("R5 fiq_out vector", 32'(fiq_out), 32'(|VTAB[v][4]));
        end
        irq_src = '0;
        wr(12'h00C, 32'h0);
        wr(12'h014, 32'hFFFF_FFFF);

        // R2: enable set/clear
        wr(12'h010, 32'h0000_000F);
        wr(12'h010, 32'h0000_00F0);
        rd_chk(12'h010, 32'h0000_00FF, "R2 set accumulates");
        wr(12'h014, 32'h0000_000F);
        rd_chk(12'h010, 32'h0000_00F0, "R2 clear");
        wr(12'h014, 32'h0);
        wr(12'h010, 32'h0);
        rd_chk(12'h010, 32'h0000_00F0, "R2 zero writes ignored");

        // R3: software set/clear and its effect on status
        wr(12'h018, 32'h0000_0011);
        rd_chk(12'h018, 32'h0000_0011, "R3 soft set");
        rd_chk(12'h000, 32'h0000_0010, "R3 soft in status");
        wr(12'h01C, 32'h0000_0001);
        rd_chk(12'h018, 32'h0000_0010, "R3 soft clear");
        wr(12'h01C, 32'hFFFF_FFFF);
        rd_chk(12'h018, 0, "R3 soft clear all");

        // R6: slot registers
        wr(12'h20C, 32'hFFFF_FFFF);
        rd_chk(12'h20C, 32'h0000_003F, "R6 control readback width");
        wr(12'h20C, 32'h0);
        wr(12'h13C, 32'hCAFE_0F00);
        rd_chk(12'h13C, 32'hCAFE_0F00, "R6 last slot address");

        // Vector setup: slot0 src5, slot1 src2, slot2 src9
        wr(12'h010, 32'hFFFF_FFFF);
        wr(12'h100, 32'h0000_A000); wr(12'h200, 32'h25);
        wr(12'h104, 32'h0000_B000); wr(12'h204, 32'h22);
        wr(12'h108, 32'h0000_C000); wr(12'h208, 32'h29);
        wr(12'h034, 32'h0000_D000);
        rd_chk(12'h034, 32'h0000_D000, "R7 default readback");
        rd_chk(12'h030, 32'h0000_D000, "R7 nothing pending gives default");
        wr(12'h018, 32'h0000_0204);
        rd_chk(12'h030, 32'h0000_B000, "R7 highest slot wins");
        rd_chk(12'h030, 32'h0000_D000, "R8 lower slot blocked");
        wr(12'h018, 32'h0000_0020);
        rd_chk(12'h030, 32'h0000_A000, "R8 higher slot preempts");
        rd_chk(12'h030, 32'h0000_D000, "R8 nothing above slot 0");
        wr(12'h01C, 32'h0000_0020);
        wr(12'h030, 32'h0);
        rd_chk(12'h030, 32'h0000_D000, "R9 one level ended, slot1 still held");
        wr(12'h030, 32'h0);
        rd_chk(12'h030, 32'h0000_B000, "R9 second end frees slot1");
        end_all();
        wr(12'h01C, 32'h0000_0004);
        rd_chk(12'h030, 32'h0000_C000, "R9 repeated ends clear all");
        end_all();
        wr(12'h00C, 32'h0000_0200);
        rd_chk(12'h030, 32'h0000_D000, "R7 fast-routed source not vectored");
        check("R4 fast output for routed source", 32'(fiq_out), 1);
        wr(12'h00C, 32'h0);
        wr(12'h01C, 32'hFFFF_FFFF);
        end_all();

        // R10: protection
        wr(12'h014, 32'hFFFF_FFFF);
        wr(12'h020, 32'h1);
        wr(12'h010, 32'h0000_0003, 1'b0);
        rd_chk(12'h010, 0, "R10 unprivileged write ignored");
        wr(12'h020, 32'h0, 1'b0);
        rd_chk(12'h020, 1, "R10 lock cannot be dropped unprivileged");
        wr(12'h010, 32'h0000_0003, 1'b1);
        rd_chk(12'h010, 32'h0000_0003, "R10 privileged write works");
        wr(12'h020, 32'h0, 1'b1);
        wr(12'h010, 32'h0000_0004, 1'b0);
        rd_chk(12'h010, 32'h0000_0007, "R10 unlocked unprivileged write works");

        // R11: identification bytes
        rd_chk(12'hFE0, 32'h90, "R11 id byte 0");
        rd_chk(12'hFE4, 32'h11, "R11 id byte 1");
        rd_chk(12'hFE8, 32'h04, "R11 id byte 2");
        rd_chk(12'hFEC, 32'h00, "R11 id byte 3");

        // R12: test control
        wr(12'h300, 32'h1);
        rd_chk(12'h300, 1, "R12 test set");
        wr(12'h300, 32'h0);
        rd_chk(12'h300, 0, "R12 test cleared");

        // R5: two-edge latency from hardware input (bit 0 enabled)
        @(negedge clk) irq_src = 32'h1;
        @(posedge clk) #1;
        check("R5 irq_out after first edge", 32'(irq_out), 0);
        @(posedge clk) #1;
        check("R5 irq_out after second edge", 32'(irq_out), 1);
        check("R5 fiq_out stays low", 32'(fiq_out), 0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule